// File: doc/BRIEF.md
# Circuit Path Setup and Timeout Controller

This per-node controller owns the life of a single outgoing bulk message on a circuit-switched on-chip network. The network is steered by a small packet-switched control plane. When a destination is presented, the controller sends a path-setup control packet at once, so the circuit is being reserved while the payload is still being prepared. The setup packet carries the randomly chosen injection and ejection lanes. The controller then waits for the circuit, releases the data transmitter for a fixed message length, and finally sends a teardown packet.

If the circuit never comes back, a timer that started with the setup fires, and a terminate packet is sent to chase the setup through the network. A path-blocked notice from the network releases the attempt. The same message is then retried after a pseudo-random backoff. The wait for the circuit runs in one of two modes. In one mode it ends on an explicit ready indication from the destination. In the other it ends after a fixed worst-case reservation wait. On the receive side, stray terminate packets addressed to this node are dropped. An acknowledgement can be returned for every message that was received and checked.

Top module: `gwc_path_ctrl`

## Requirements
- R1: A request is taken only while `req_ready` is high (idle). A setup packet (kind 0) carrying the request's destination appears on the control output in the cycle after acceptance. Requests presented while busy produce nothing.
- R2: In a setup packet, `ctl_tx_route` holds the injection lane in its upper half and the ejection lane in its lower half. Each lane is below NLANES.
- R3: In ready mode (`mode_fixed_wait`=0), a ready notice (rx kind 0) while waiting raises `data_tx_en` in the next cycle. It stays high for exactly MSG_CYC cycles.
- R4: In fixed-wait mode (`mode_fixed_wait`=1, sampled with the request), `data_tx_en` rises ASSUME_CYC cycles after the setup cycle, with no ready notice.
- R5: A teardown packet (kind 1) to the same destination appears in the first cycle after transmission ends. `req_ready` is high again in that cycle.
- R6: In ready mode with no reply, a terminate packet (kind 2) to the destination appears TIMEOUT cycles after the setup cycle.
- R7: A path-blocked notice (rx kind 1), whether received while waiting or after a terminate, transmits no data. The setup to the same destination is resent 2 to 2^BO_W+1 cycles after the notice cycle.
- R8: A ready notice that arrives after the terminate was sent still starts transmission in the next cycle.
- R9: A terminate packet received from the network (rx kind 2) is discarded. No control packet results, and transmission and `req_ready` are unaffected.
- R10: With ACK_EN=1, a received-and-checked notice (rx kind 3) produces an acknowledgement (kind 3) addressed to `ctl_rx_src` two cycles later. If the controller's own packet needs the output in that slot, the acknowledgement follows one cycle later.
- R11: During and right after reset, no control packet is sent, `data_tx_en` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A message is waiting to be sent |
| req_dest | input | DEST_W | Destination node of the message |
| req_ready | output | 1 | Controller is idle and takes the request |
| mode_fixed_wait | input | 1 | 1: assume the path after ASSUME_CYC cycles; 0: wait for a ready notice |
| ctl_rx_valid | input | 1 | Incoming control notice strobe |
| ctl_rx_kind | input | 2 | 0 ready, 1 path blocked, 2 terminate, 3 message received and checked |
| ctl_rx_src | input | DEST_W | Node that originated the notice |
| ctl_tx_valid | output | 1 | Outgoing control packet strobe |
| ctl_tx_kind | output | 2 | 0 setup, 1 teardown, 2 terminate, 3 acknowledgement |
| ctl_tx_dest | output | DEST_W | Destination of the outgoing control packet |
| ctl_tx_route | output | 2*LANE_W | {injection lane, ejection lane} for setup, zero otherwise |
| data_tx_en | output | 1 | Data transmitter released for the message |

## Verification
The assertions take for granted that the network answers every setup with a ready notice, a path-blocked notice, or both. They also assume that the incoming strobe carries at most one notice per cycle, and that `mode_fixed_wait` is held steady during a message. The stimulus sends only notices that fit the controller's current phase: a ready notice after a setup or a terminate, a blocked notice before transmission, and received-message notices spaced apart so that only one acknowledgement is ever pending. Requests are raised only while idle, except for deliberate pulses during a busy phase that check they are dropped.

// File: rtl/gwc_pkg.sv
package gwc_pkg;
  typedef enum logic [1:0] {
    TX_SETUP     = 2'd0,
    TX_TEARDOWN  = 2'd1,
    TX_TERMINATE = 2'd2,
    TX_ACK       = 2'd3
  } tx_kind_e;

  typedef enum logic [1:0] {
    RX_READY     = 2'd0,
    RX_BLOCKED   = 2'd1,
    RX_TERMINATE = 2'd2,
    RX_DONE      = 2'd3
  } rx_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XMIT,
    ST_DRAIN,
    ST_BACKOFF
  } state_e;
endpackage

// File: rtl/gwc_lfsr.sv
module gwc_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] q, q_n;

  always_comb begin
    q_n = {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_n;
  end

  assign value = q;
endmodule

// File: rtl/gwc_down_counter.sv
module gwc_down_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         cnt_en,
  output logic         zero
);
  logic [W-1:0] q, q_n;

  always_comb begin
    q_n = q;
    if (load)                q_n = load_val;
    else if (cnt_en && q != '0) q_n = q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  assign zero = (q == '0);
endmodule

// File: rtl/gwc_ack_slot.sv
module gwc_ack_slot #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [DW-1:0] set_dest,
  input  logic          grant,
  output logic          pending,
  output logic [DW-1:0] dest
);
  logic          pend_q, pend_n;
  logic [DW-1:0] dest_q;

  always_comb begin
    pend_n = (pend_q && !grant) || set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dest_q <= '0;
    end else begin
      pend_q <= pend_n;
      if (set) dest_q <= set_dest;
    end
  end

  assign pending = pend_q;
  assign dest    = dest_q;

  // R10: the sender only grants an acknowledgement that is actually waiting
  assert_grant_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> pend_q);
endmodule

// File: rtl/gwc_path_ctrl.sv
module gwc_path_ctrl
  import gwc_pkg::*;
#(
  parameter int  DEST_W     = 4,
  parameter int  NLANES     = 3,
  parameter int  TIMEOUT    = 40,
  parameter int  ASSUME_CYC = 12,
  parameter int  MSG_CYC    = 10,
  parameter int  BO_W       = 3,
  parameter bit  ACK_EN     = 1'b1,
  localparam int LANE_W     = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [DEST_W-1:0]   req_dest,
  output logic                req_ready,
  input  logic                mode_fixed_wait,
  input  logic                ctl_rx_valid,
  input  logic [1:0]          ctl_rx_kind,
  input  logic [DEST_W-1:0]   ctl_rx_src,
  output logic                ctl_tx_valid,
  output logic [1:0]          ctl_tx_kind,
  output logic [DEST_W-1:0]   ctl_tx_dest,
  output logic [2*LANE_W-1:0] ctl_tx_route,
  output logic                data_tx_en
);
  localparam int M1   = (TIMEOUT > ASSUME_CYC) ? TIMEOUT : ASSUME_CYC;
  localparam int M2   = (MSG_CYC > (1 << BO_W)) ? MSG_CYC : (1 << BO_W);
  localparam int MAXV = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXV + 1);
  localparam int RW   = 16;

  state_e              state_q, state_n;
  logic [DEST_W-1:0]   dest_q, dest_n;
  logic                fixed_q, fixed_n;
  logic                cnt_ld, cnt_en, cnt_zero;
  logic [CW-1:0]       cnt_val;
  logic                fsm_tx_v;
  tx_kind_e            fsm_tx_kind;
  logic [RW-1:0]       rnd;
  logic [LANE_W-1:0]   inj_lane, ej_lane;
  logic [CW-1:0]       bo_val;
  logic                rx_ready, rx_blocked, rx_done;
  logic                ack_pending, ack_grant;
  logic [DEST_W-1:0]   ack_dest;
  logic                tx_valid_n, tx_valid_q;
  tx_kind_e            tx_kind_n, tx_kind_q;
  logic [DEST_W-1:0]   tx_dest_n, tx_dest_q;
  logic [2*LANE_W-1:0] tx_route_n, tx_route_q;

  gwc_lfsr #(.W(RW)) u_rnd (.clk(clk), .rst_n(rst_n), .value(rnd));

  gwc_down_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_ld), .load_val(cnt_val),
    .cnt_en(cnt_en), .zero(cnt_zero));

  assign inj_lane = LANE_W'(rnd[7:0] % NLANES);
  assign ej_lane  = LANE_W'(rnd[15:8] % NLANES);
  assign bo_val   = CW'(rnd[BO_W+3:4]);

  assign rx_ready   = ctl_rx_valid && (ctl_rx_kind == RX_READY);
  assign rx_blocked = ctl_rx_valid && (ctl_rx_kind == RX_BLOCKED);
  assign rx_done    = ctl_rx_valid && (ctl_rx_kind == RX_DONE);

  // Path wait length depends on the wait mode captured with the request
  function automatic logic [CW-1:0] wait_len(input logic fixed);
    return fixed ? CW'(ASSUME_CYC - 1) : CW'(TIMEOUT - 1);
  endfunction

  always_comb begin
    state_n     = state_q;
    dest_n      = dest_q;
    fixed_n     = fixed_q;
    cnt_ld      = 1'b0;
    cnt_val     = '0;
    cnt_en      = 1'b0;
    fsm_tx_v    = 1'b0;
    fsm_tx_kind = TX_SETUP;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        dest_n   = req_dest;
        fixed_n  = mode_fixed_wait;
        cnt_ld   = 1'b1;
        cnt_val  = wait_len(mode_fixed_wait);
        fsm_tx_v = 1'b1;
        state_n  = ST_WAIT;
      end
      ST_WAIT: begin
        cnt_en = 1'b1;
        if (rx_blocked) begin
          cnt_ld = 1'b1; cnt_val = bo_val; state_n = ST_BACKOFF;
        end else if ((rx_ready && !fixed_q) || (cnt_zero && fixed_q)) begin
          cnt_ld = 1'b1; cnt_val = CW'(MSG_CYC - 1); state_n = ST_XMIT;
        end else if (cnt_zero) begin
          fsm_tx_v = 1'b1; fsm_tx_kind = TX_TERMINATE; state_n = ST_DRAIN;
        end
      end
      ST_XMIT: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          fsm_tx_v = 1'b1; fsm_tx_kind = TX_TEARDOWN; state_n = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (rx_blocked) begin
          cnt_ld = 1'b1; cnt_val = bo_val; state_n = ST_BACKOFF;
        end else if (rx_ready) begin
          cnt_ld = 1'b1; cnt_val = CW'(MSG_CYC - 1); state_n = ST_XMIT;
        end
      end
      ST_BACKOFF: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          cnt_ld = 1'b1; cnt_val = wait_len(fixed_q);
          fsm_tx_v = 1'b1; state_n = ST_WAIT;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  generate
    if (ACK_EN) begin : g_ack
      gwc_ack_slot #(.DW(DEST_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .set(rx_done), .set_dest(ctl_rx_src),
        .grant(ack_grant), .pending(ack_pending), .dest(ack_dest));
    end else begin : g_no_ack
      assign ack_pending = 1'b0;
      assign ack_dest    = '0;
    end
  endgenerate

  // Own packets win the output; an acknowledgement takes the next free slot
  always_comb begin
    ack_grant  = ack_pending && !fsm_tx_v;
    tx_valid_n = fsm_tx_v || ack_grant;
    tx_kind_n  = fsm_tx_v ? fsm_tx_kind : TX_ACK;
    tx_dest_n  = fsm_tx_v ? dest_n : ack_dest;
    tx_route_n = (fsm_tx_v && fsm_tx_kind == TX_SETUP) ? {inj_lane, ej_lane} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      dest_q     <= '0;
      fixed_q    <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_kind_q  <= TX_SETUP;
      tx_dest_q  <= '0;
      tx_route_q <= '0;
    end else begin
      state_q    <= state_n;
      dest_q     <= dest_n;
      fixed_q    <= fixed_n;
      tx_valid_q <= tx_valid_n;
      if (tx_valid_n) begin
        tx_kind_q  <= tx_kind_n;
        tx_dest_q  <= tx_dest_n;
        tx_route_q <= tx_route_n;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign data_tx_en   = (state_q == ST_XMIT);
  assign ctl_tx_valid = tx_valid_q;
  assign ctl_tx_kind  = tx_kind_q;
  assign ctl_tx_dest  = tx_dest_q;
  assign ctl_tx_route = tx_route_q;

  assert_setup_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (ctl_tx_valid && ctl_tx_kind == TX_SETUP && ctl_tx_dest == $past(req_dest)));

  assert_lane_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_tx_valid && ctl_tx_kind == TX_SETUP) |->
      (ctl_tx_route[2*LANE_W-1:LANE_W] < NLANES && ctl_tx_route[LANE_W-1:0] < NLANES));

  assert_teardown_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_tx_en) |-> (ctl_tx_valid && ctl_tx_kind == TX_TEARDOWN && req_ready));

  assert_ack_sent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pending && !fsm_tx_v) |=> (ctl_tx_valid && ctl_tx_kind == TX_ACK));
endmodule

// File: tb/sim_gwc_path_ctrl.sv
module sim_gwc_path_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;
  localparam int ASM = 12;
  localparam int MSG = 10;
  localparam int BOW = 3;
  localparam int NL  = 3;
  localparam int DW  = 4;
  localparam int LW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [DW-1:0] req_dest = '0;
  logic req_ready;
  logic mode_fixed_wait = 1'b0;
  logic ctl_rx_valid = 1'b0;
  logic [1:0] ctl_rx_kind = 2'd0;
  logic [DW-1:0] ctl_rx_src = '0;
  logic ctl_tx_valid;
  logic [1:0] ctl_tx_kind;
  logic [DW-1:0] ctl_tx_dest;
  logic [2*LW-1:0] ctl_tx_route;
  logic data_tx_en;

  int total = 0;
  int bad = 0;
  int ncyc = 0;

  typedef struct { int kind; int dest; } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  gwc_path_ctrl #(.DEST_W(DW), .NLANES(NL), .TIMEOUT(TMO), .ASSUME_CYC(ASM),
                  .MSG_CYC(MSG), .BO_W(BOW), .ACK_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_ready(req_ready), .mode_fixed_wait(mode_fixed_wait),
    .ctl_rx_valid(ctl_rx_valid), .ctl_rx_kind(ctl_rx_kind), .ctl_rx_src(ctl_rx_src),
    .ctl_tx_valid(ctl_tx_valid), .ctl_tx_kind(ctl_tx_kind), .ctl_tx_dest(ctl_tx_dest),
    .ctl_tx_route(ctl_tx_route), .data_tx_en(data_tx_en));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int dest);
    exp_t e;
    e.kind = kind; e.dest = dest;
    expq.push_back(e);
  endtask

  // Monitor: every emitted packet must match the next expected one
  always @(negedge clk) begin
    if (rst_n && ctl_tx_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected packet kind", int'(ctl_tx_kind), -1);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(int'(ctl_tx_kind) == e.kind, "R1 packet kind", int'(ctl_tx_kind), e.kind);
        chk(int'(ctl_tx_dest) == e.dest, "R1 packet dest", int'(ctl_tx_dest), e.dest);
        if (e.kind == 0) begin
          chk(int'(ctl_tx_route[2*LW-1:LW]) < NL, "R2 inject lane", int'(ctl_tx_route[2*LW-1:LW]), NL - 1);
          chk(int'(ctl_tx_route[LW-1:0]) < NL, "R2 eject lane", int'(ctl_tx_route[LW-1:0]), NL - 1);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(input int dest, output int st);
    chk(req_ready, "R1 idle before request", int'(req_ready), 1);
    push(0, dest);
    req_valid = 1'b1; req_dest = DW'(dest);
    @(negedge clk);
    req_valid = 1'b0;
    st = ncyc;
    chk(ctl_tx_valid && ctl_tx_kind == 2'd0, "R1 setup next cycle", int'(ctl_tx_kind), 0);
  endtask

  task automatic rx(input int kind, input int src, output int st);
    ctl_rx_valid = 1'b1; ctl_rx_kind = 2'(kind); ctl_rx_src = DW'(src);
    st = ncyc;
    @(negedge clk);
    ctl_rx_valid = 1'b0;
  endtask

  task automatic wait_pkt(input int kind, output int st);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(ctl_tx_valid && int'(ctl_tx_kind) == kind) && guard < 2000);
    st = ncyc;
    chk(guard < 2000, "R6 packet wait", guard, 0);
  endtask

  task automatic xmit_check(input int exp_rise, input string tag);
    int guard = 0;
    int n = 0;
    while (!data_tx_en && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(ncyc == exp_rise, tag, ncyc, exp_rise);
    while (data_tx_en && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk(n == MSG, "R3 transmit length", n, MSG);
    chk(ctl_tx_valid && ctl_tx_kind == 2'd1, "R5 teardown after data", int'(ctl_tx_kind), 1);
    chk(req_ready, "R5 idle after teardown", int'(req_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, t, r, b, d, a, n;
    // R11 reset state
    tick(3);
    chk(!ctl_tx_valid && !data_tx_en && req_ready, "R11 in reset", int'(ctl_tx_valid), 0);
    rst_n = 1'b1;
    tick(3);
    chk(!ctl_tx_valid && !data_tx_en && req_ready, "R11 after reset", int'(data_tx_en), 0);

    // R1/R3/R9/R5: ready mode, busy requests dropped, stray terminate
    do_req(5, s);
    tick(3);
    chk(!req_ready, "R1 busy while waiting", int'(req_ready), 0);
    req_valid = 1'b1; req_dest = 4'd9;
    tick(2);
    req_valid = 1'b0;
    push(1, 5);
    rx(0, 5, r);
    chk(data_tx_en && ncyc == r + 1, "R3 data starts after ready", ncyc, r + 1);
    rx(2, 1, t);
    chk(data_tx_en && !req_ready, "R9 stray terminate ignored", int'(data_tx_en), 1);
    n = 1;
    while (data_tx_en && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk(n == MSG, "R3 transmit length", n, MSG);
    chk(ctl_tx_valid && ctl_tx_kind == 2'd1, "R5 teardown", int'(ctl_tx_kind), 1);
    chk(req_ready, "R5 idle again", int'(req_ready), 1);
    tick(2);

    // R6/R7: timeout, terminate, blocked after terminate, blocked while waiting
    do_req(3, s);
    push(2, 3);
    wait_pkt(2, t);
    chk(t - s == TMO, "R6 terminate delay", t - s, TMO);
    push(0, 3);
    rx(1, 3, b);
    chk(!data_tx_en, "R7 no data after block", int'(data_tx_en), 0);
    wait_pkt(0, s);
    chk(s - b >= 2 && s - b <= (1 << BOW) + 1, "R7 backoff window", s - b, 2);
    push(0, 3);
    rx(1, 3, b);
    wait_pkt(0, s);
    chk(s - b >= 2 && s - b <= (1 << BOW) + 1, "R7 backoff window again", s - b, 2);
    chk(!data_tx_en, "R7 still no data", int'(data_tx_en), 0);
    push(1, 3);
    rx(0, 3, r);
    xmit_check(r + 1, "R3 data after retry");
    tick(2);

    // R8: ready after terminate
    do_req(7, s);
    push(2, 7);
    wait_pkt(2, t);
    push(1, 7);
    rx(0, 7, r);
    xmit_check(r + 1, "R8 ready after terminate");
    tick(2);

    // R4: fixed-wait mode
    mode_fixed_wait = 1'b1;
    do_req(2, s);
    push(1, 2);
    xmit_check(s + ASM, "R4 assumed path delay");
    mode_fixed_wait = 1'b0;
    tick(2);

    // R10: acknowledgement in a free slot
    push(3, 11);
    rx(3, 11, d);
    wait_pkt(3, a);
    chk(a == d + 2, "R10 ack delay", a, d + 2);
    tick(2);

    // R10: acknowledgement deferred behind own setup
    push(0, 6);
    push(3, 12);
    ctl_rx_valid = 1'b1; ctl_rx_kind = 2'd3; ctl_rx_src = 4'd12;
    d = ncyc;
    @(negedge clk);
    ctl_rx_valid = 1'b0;
    req_valid = 1'b1; req_dest = 4'd6;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ctl_tx_valid && ctl_tx_kind == 2'd0 && ncyc == d + 2, "R10 setup first", int'(ctl_tx_kind), 0);
    @(negedge clk);
    chk(ctl_tx_valid && ctl_tx_kind == 2'd3 && ncyc == d + 3, "R10 ack deferred", int'(ctl_tx_kind), 3);
    push(1, 6);
    rx(0, 6, r);
    xmit_check(r + 1, "R3 data after deferred ack");

    tick(20);
    chk(expq.size() == 0, "R5 all expected packets seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule